// File: doc/BRIEF.md
# Sigma-Delta Converter Digital Back-End

This block is the digital half of a first-order sigma-delta analog-to-digital converter whose integrator is an external resistor and capacitor. Every clock it registers the one-bit comparator decision and drives that registered bit straight back out to charge or discharge the external capacitor. The same registered bit feeds a fixed-point model of the capacitor node. Because the capacitor charges through a resistor rather than from a constant current, its step depends on how far the node is from the rail. The model applies that same exponential step, so its level tracks the real node and the conversion stays linear.

The model's level then passes through an accumulate-and-dump low-pass filter. This filter sums the upper bits of the level over a fixed window of clocks and emits one averaged sample per window, with a one-clock valid strobe. The model must sit ahead of the filter and work on the raw bit stream. The step coefficient is a power of two, so the multiply is only an arithmetic shift. A typical setting runs from a 100 MHz clock and delivers samples in the tens of kilohertz.

Top module: `sdadc_backend`

## Requirements
- R1: `fb_out` equals the value `cmp_in` had at the previous rising clock edge, so it is registered exactly once.
- R2: The model level is a W-bit unsigned value. On every clock outside reset it moves toward a target, which is 2^W−1 when the registered bit (`fb_out`) is 1 and 0 when that bit is 0. The step added is (target − level) arithmetically shifted right by SHIFT, which rounds toward minus infinity.
- R3: Reset loads the model level with mid-scale, 2^(W−1).
- R4: At the end of each window of 2^DEC clocks, `sample` becomes floor(S / 2^DEC). S is the sum, over the 2^DEC clocks of that window, of the model level's top N bits (level[W−1:W−N]) as they stood before each clock edge.
- R5: `sample_valid` is high for exactly one clock per window. It rises 2^DEC clocks after reset is released, and then every 2^DEC clocks after that.
- R6: A synchronous active-high `rst` clears the feedback bit, the accumulator, the window count, `sample` and `sample_valid`. A reset in the middle of a window discards the partial sum, and the next window starts with a full 2^DEC clocks.
- R7: A steady all-ones input settles to code 2^N−1 and a steady all-zeros input settles to code 0, with no wrap-around at either end.
- R8: In a closed loop with an RC node whose coefficient matches 2^−SHIFT, each settled sample lies within ±2 LSB of the node's mean level over its window. Codes rise as the input voltage rises.
- R9: `sample` holds its value in every clock that carries no valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Comparator decision from the differential input buffer |
| fb_out | output | 1 | Registered bit driven back to the external RC network |
| sample | output | N | Decimated, linearised conversion result |
| sample_valid | output | 1 | One-clock strobe marking a new `sample` |

## Verification
The hardest condition to reach from the ports is a real closed loop, where the bit stream depends on the converter's own feedback and on an input voltage. The bench builds this loop by stepping a behavioural RC node with the same shift coefficient, driven from `fb_out`, and deriving `cmp_in` by comparing that node with a held input level. It holds three input levels, waits for each to settle, and compares each sample with the node's window mean. A reset issued partway through a window is the other hard case. The bench checks that the partial sum is lost and that the next strobe arrives exactly one full window later.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

  // One step of the exponential charge curve of the RC node.
  // The level moves toward the rail selected by drive_hi by a fraction
  // 2^-shift of the remaining distance, with the arithmetic shift
  // rounding toward minus infinity.
  function automatic logic [31:0] rc_step(input logic [31:0] level,
                                          input logic        drive_hi,
                                          input int unsigned width,
                                          input int unsigned shift);
    longint signed rail;
    longint signed gap;
    longint signed nxt;
    rail = drive_hi ? ((longint'(1) << width) - 64'sd1) : 64'sd0;
    gap  = rail - longint'(level);
    nxt  = longint'(level) + (gap >>> shift);
    return 32'(nxt);
  endfunction

  // Mid-scale value of a width-bit unsigned level.
  function automatic logic [31:0] mid_scale(input int unsigned width);
    return 32'(longint'(1) << (width - 1));
  endfunction

endpackage

// File: rtl/sdadc_fb_sampler.sv
module sdadc_fb_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in,
  output logic bit_q
);
  // Single register: the sampled comparator bit is both the feedback
  // drive and the model's input.
  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= cmp_in;
  end
endmodule

// File: rtl/sdadc_rc_model.sv
module sdadc_rc_model #(
  parameter int W     = 16,
  parameter int SHIFT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  output logic [W-1:0] level
);
  localparam logic [W-1:0] MID = W'(sdadc_pkg::mid_scale(W));

  logic [W-1:0] level_q;
  logic [W-1:0] level_d;

  always_comb level_d = W'(sdadc_pkg::rc_step(32'(level_q), bit_in, W, SHIFT));

  always_ff @(posedge clk) begin
    if (rst) level_q <= MID;
    else     level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/sdadc_decimator.sv
module sdadc_decimator #(
  parameter int N   = 8,
  parameter int DEC = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] top_in,
  output logic [N-1:0] sample,
  output logic         valid,
  output logic         win_end
);
  localparam int           ACC_W = N + DEC;
  localparam logic [DEC-1:0] LAST = '1;

  logic [DEC-1:0]   pos_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_w;
  logic [N-1:0]     sample_q;
  logic             valid_q;

  // Window average: drop the DEC fraction bits of the sum.
  function automatic logic [N-1:0] window_mean(input logic [ACC_W-1:0] s);
    return N'(s >> DEC);
  endfunction

  assign sum_w   = acc_q + ACC_W'(top_in);
  assign win_end = (pos_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      acc_q    <= '0;
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      pos_q <= pos_q + 1'b1;
      if (win_end) begin
        acc_q    <= '0;
        sample_q <= window_mean(sum_w);
        valid_q  <= 1'b1;
      end else begin
        acc_q    <= sum_w;
        valid_q  <= 1'b0;
      end
    end
  end

  assign sample = sample_q;
  assign valid  = valid_q;
endmodule

// File: rtl/sdadc_backend.sv
module sdadc_backend #(
  parameter int N     = 8,
  parameter int W     = 16,
  parameter int SHIFT = 4,
  parameter int DEC   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_in,
  output logic         fb_out,
  output logic [N-1:0] sample,
  output logic         sample_valid
);
  logic         bit_q;
  logic [W-1:0] level_q;
  logic [N-1:0] level_top;
  logic         win_end;

  function automatic logic [N-1:0] top_bits(input logic [W-1:0] lv);
    return lv[W-1 -: N];
  endfunction

  sdadc_fb_sampler u_sampler (
    .clk    (clk),
    .rst    (rst),
    .cmp_in (cmp_in),
    .bit_q  (bit_q)
  );

  sdadc_rc_model #(.W(W), .SHIFT(SHIFT)) u_model (
    .clk    (clk),
    .rst    (rst),
    .bit_in (bit_q),
    .level  (level_q)
  );

  assign level_top = top_bits(level_q);

  sdadc_decimator #(.N(N), .DEC(DEC)) u_decim (
    .clk     (clk),
    .rst     (rst),
    .top_in  (level_top),
    .sample  (sample),
    .valid   (sample_valid),
    .win_end (win_end)
  );

  assign fb_out = bit_q;
endmodule

// File: rtl/sdadc_backend_chk.sv
module sdadc_backend_chk #(
  parameter int N   = 8,
  parameter int W   = 16,
  parameter int DEC = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cmp_in,
  input logic         fb_out,
  input logic [N-1:0] sample,
  input logic         sample_valid,
  input logic [W-1:0] level,
  input logic         win_end
);
  localparam int           SW  = DEC + 2;
  localparam logic [SW-1:0] WIN = SW'(1) << DEC;
  localparam logic [W-1:0]  MID = W'(1) << (W - 1);

  logic          armed = 1'b0;
  logic [SW-1:0] since;

  always_ff @(posedge clk) armed <= armed | rst;

  always_ff @(posedge clk) begin
    if (rst)                since <= '0;
    else if (sample_valid)  since <= SW'(1);
    else if (since != '1)   since <= since + 1'b1;
  end

  AST_FB_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(rst) |-> fb_out == $past(cmp_in)); // R1
  AST_MODEL_RISES: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(fb_out)) |-> level >= $past(level)); // R2
  AST_MODEL_FALLS: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(fb_out)) |-> level <= $past(level)); // R2
  AST_MODEL_MID: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> level == MID); // R3
  AST_WINDOW_STROBE: assert property (@(posedge clk) disable iff (rst || !armed)
    win_end |=> sample_valid); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst || !armed)
    sample_valid |=> !sample_valid); // R5
  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (rst || !armed)
    sample_valid |-> since == WIN); // R5
  AST_VALID_NOT_LATE: assert property (@(posedge clk) disable iff (rst || !armed)
    !sample_valid |-> since < WIN); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> (!fb_out && !sample_valid && sample == '0)); // R6
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
    (!sample_valid && !$past(rst)) |-> $stable(sample)); // R9
endmodule

bind sdadc_backend sdadc_backend_chk #(.N(N), .W(W), .DEC(DEC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmp_in       (cmp_in),
  .fb_out       (fb_out),
  .sample       (sample),
  .sample_valid (sample_valid),
  .level        (level_q),
  .win_end      (win_end)
);

// File: tb/sdadc_backend_test.sv
module sdadc_backend_test;
  localparam int N     = 8;
  localparam int W     = 16;
  localparam int SHIFT = 4;
  localparam int DEC   = 8;
  localparam int WIN   = 1 << DEC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_in = 1'b0;
  logic fb_out;
  logic [N-1:0] sample;
  logic sample_valid;

  always #5 clk = ~clk;

  sdadc_backend #(.N(N), .W(W), .SHIFT(SHIFT), .DEC(DEC)) uut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in),
    .fb_out(fb_out), .sample(sample), .sample_valid(sample_valid)
  );

  typedef struct {
    longint due;
    int     code;
    int     ana;   // -1 when no analog comparison applies
  } exp_t;

  exp_t   sbq[$];
  int     n_cmp = 0;
  int     n_bad = 0;
  longint cyc = 0;
  bit     done = 1'b0;
  int     last_code = -1;

  // bench model state
  longint m_level;
  int     m_dout;
  longint m_sum;
  int     m_pos;
  real    v_node;
  real    v_sum;
  bit     ana_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp, input int tol);
    n_cmp++;
    if (act > exp + tol || act < exp - tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d) at cycle %0d", req, act, exp, tol, cyc);
    end
  endtask

  // Level after one step toward the selected rail, floor division by 2^SHIFT.
  function automatic longint next_level(longint lvl, int b);
    longint aim, gap, q, step;
    aim = b ? ((longint'(1) << W) - 1) : 0;
    gap = aim - lvl;
    q   = longint'(1) << SHIFT;
    if (gap >= 0) step = gap / q;
    else          step = -((-gap + q - 1) / q);
    return lvl + step;
  endfunction

  // Driver: entered and left at a falling edge; models the coming rising edge.
  task automatic drive_bit(input int b);
    m_sum += m_level / (longint'(1) << (W - N));
    v_sum += v_node;
    if (m_pos == WIN - 1) begin
      exp_t e;
      e.due  = cyc + 1;
      e.code = int'(m_sum / WIN);
      // top-bit truncation biases the window mean low by up to one LSB
      e.ana  = ana_on ? $rtoi((v_sum / WIN) * (1 << N) - 0.5) : -1;
      sbq.push_back(e);
      m_sum = 0;
      v_sum = 0.0;
      m_pos = 0;
    end else begin
      m_pos++;
    end
    m_level = next_level(m_level, m_dout);
    v_node  = v_node + (real'(m_dout) - v_node) / real'(1 << SHIFT);
    m_dout  = b;
    cmp_in  = b[0];
    @(negedge clk);
  endtask

  task automatic do_reset(input int cycles);
    rst = 1'b1;
    cmp_in = 1'b0;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
    m_level = longint'(1) << (W - 1);
    m_dout = 0;
    m_sum = 0;
    m_pos = 0;
    v_node = 0.5;
    v_sum = 0.0;
    sbq.delete();
  endtask

  task automatic run_closed(input real vin, input int windows);
    for (int k = 0; k < windows * WIN; k++) begin
      ana_on = (k >= 2 * WIN);
      drive_bit((vin > v_node) ? 1 : 0);
    end
    ana_on = 1'b0;
  endtask

  // Monitor: samples 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst) begin
        check("R6 fb_out in reset", fb_out, 0, 0);
        check("R6 valid in reset", sample_valid, 0, 0);
        check("R6 sample in reset", sample, 0, 0);
      end else begin
        check("R1 feedback follows comparator", fb_out, cmp_in, 0);
        if (sample_valid) begin
          if (sbq.size() == 0) begin
            check("R5 unexpected valid", 1, 0, 0);
          end else begin
            exp_t e;
            e = sbq.pop_front();
            check("R5 valid timing", cyc, e.due, 0);
            check("R4 window code (R2 model)", sample, e.code, 0);
            if (e.ana >= 0) check("R8 closed-loop code", sample, e.ana, 2);
          end
          last_code = int'(sample);
        end else if (sbq.size() != 0 && sbq[0].due == cyc) begin
          void'(sbq.pop_front());
          check("R5 missing valid", 0, 1, 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    int c_lo, c_mid, c_hi;
    lf = 16'hACE1;
    @(negedge clk);
    do_reset(3);
    // R6 reset state seen at the ports, R3 mid-scale start via first window
    check("R6 post-reset sample", sample, 0, 0);
    check("R6 post-reset valid", sample_valid, 0, 0);

    // all zeros: R3 start at mid-scale, R7 floor
    for (int k = 0; k < 3 * WIN; k++) drive_bit(0);
    check("R7 all-zeros code", last_code, 0, 0);

    // all ones: R7 ceiling, no wrap
    for (int k = 0; k < 3 * WIN; k++) drive_bit(1);
    check("R7 all-ones code", last_code, (1 << N) - 1, 0);

    // alternating bits
    for (int k = 0; k < 2 * WIN; k++) drive_bit(k % 2);

    // pseudo-random stream
    for (int k = 0; k < 4 * WIN; k++) begin
      drive_bit(int'(lf[0]));
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end

    // R6 reset in the middle of a window, then full windows
    for (int k = 0; k < 100; k++) drive_bit((k % 3 == 0) ? 1 : 0);
    do_reset(2);
    for (int k = 0; k < 2 * WIN; k++) drive_bit((k % 4 == 0) ? 0 : 1);

    // R8 closed loop at three input levels
    do_reset(2);
    run_closed(0.2, 6);
    c_lo = last_code;
    run_closed(0.5, 6);
    c_mid = last_code;
    run_closed(0.8, 6);
    c_hi = last_code;
    check("R8 monotonic low<mid", (c_mid > c_lo) ? 1 : 0, 1, 0);
    check("R8 monotonic mid<high", (c_hi > c_mid) ? 1 : 0, 1, 0);

    // R9 hold: no strobe for a while after reset, sample stays at reset value
    do_reset(2);
    for (int k = 0; k < WIN - 1; k++) drive_bit(1);
    check("R9 sample held before first strobe", sample, 0, 0);
    drive_bit(1);

    repeat (3) @(negedge clk);
    check("R5 all expected samples seen", sbq.size(), 0, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule